// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block moves an 18-bit word between an A port and a B port in both directions at once. Each direction has its own control trio: an output enable, a pass-through select and a capture strobe. With the pass-through select high, the far port follows the near port's input in the same cycle. With the select low, the far port drives a stored word. That word is replaced only when the capture strobe goes from high to low.

Both directions are built from one lane module. They differ only in the polarity of the output enable. The A-to-B enable is active high and the B-to-A enable is active low. No tri-state nets are used. Each port drives a data-out vector and one drive-enable bit, and any resolver outside the block uses that bit to decide whether the port drives the bus. While a direction is disabled, its data-out is forced to zero.

The strobes are sampled on the core clock `clk_i`. A falling strobe is detected when one clock edge sees it high and the next clock edge sees it low. The capture happens at that second edge.

Top module: `bus_xcvr_dual`

## Requirements
- R1: The data width is set by parameter DATA_W (default 18). All DATA_W bits pass through in both directions, including bit DATA_W-1.
- R2: When a direction's pass-through select is high and its output is enabled, the far data-out equals the near data-in in the same cycle.
- R3: When the select is low and no falling strobe is detected, the far data-out drives the stored word. Changes on the near data-in have no effect on it.
- R4: When the select is low and the strobe is sampled high at one clock edge and low at the next, the near data-in is stored at that second edge. It appears on the far data-out from then on. A rising strobe stores nothing.
- R5: While the select is high, the store loads the input at every clock edge. After the select falls, the far data-out holds the input sampled at the last edge where the select was high.
- R6: The A-to-B enable `oe_ab_i` is active high. `b_oe_o` equals it. While it is low, `b_o` is all zeros, but storage keeps updating.
- R7: The B-to-A enable `oe_ba_ni` is active low. `a_oe_o` is its inverse. While `a_oe_o` is low, `a_o` is all zeros.
- R8: When reset is asserted (`rst_ni` low), both stored words clear to zero and both strobe histories clear to low. Until the next capture, a direction with its select low drives zero.
- R9: The two directions are independent. A store in one direction never alters the word held by the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock; strobes are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | DATA_W | Data received on the A port |
| a_o | output | DATA_W | Data driven onto the A port (B-to-A direction) |
| a_oe_o | output | 1 | A port drive enable |
| b_i | input | DATA_W | Data received on the B port |
| b_o | output | DATA_W | Data driven onto the B port (A-to-B direction) |
| b_oe_o | output | 1 | B port drive enable |
| oe_ab_i | input | 1 | A-to-B output enable, active high |
| le_ab_i | input | 1 | A-to-B pass-through select |
| strb_ab_i | input | 1 | A-to-B capture strobe, stores on falling transition |
| oe_ba_ni | input | 1 | B-to-A output enable, active low |
| le_ba_i | input | 1 | B-to-A pass-through select |
| strb_ba_i | input | 1 | B-to-A capture strobe, stores on falling transition |

## Verification
- **Directed sequences.** These cover the reset value, alternating-bit words with the select held and then dropped, and a high-then-low strobe against a rising-only strobe. Together they separate the pass, hold and capture paths and show whether the select edge drops the last transparent word.
- **Cross-direction test.** One direction is pulsed while the other holds a distinct word, so that any shared storage shows up as a corrupted held value.
- **Random phase.** Random words, selects, strobes and enables on both sides are compared every cycle with a behavioural model. This catches wrong enable polarity, a missing zero gate and captures on the wrong strobe edge.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  typedef enum logic [1:0] {
    XM_PASS    = 2'd0,
    XM_HOLD    = 2'd1,
    XM_CAPTURE = 2'd2
  } xcvr_mode_e;
endpackage

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= strb_i;
  end

  assign fall_o = prev_q & ~strb_i;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import bus_xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  xcvr_mode_e   mode_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (mode_i != XM_HOLD) q_o <= d_i;
  end

  assert_pass_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == XM_PASS) |=> (q_o == $past(d_i)));
  assert_capture_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == XM_CAPTURE) |=> (q_o == $past(d_i)));
  assert_hold_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == XM_HOLD) |=> $stable(q_o));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import bus_xcvr_pkg::*;
#(
  parameter int W      = 18,
  parameter bit OE_LOW = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         oe_raw_i,
  input  logic         le_i,
  input  logic         strb_i,
  output logic [W-1:0] y_o,
  output logic         oe_o
);
  logic       fall;
  logic       en;
  xcvr_mode_e mode;
  logic [W-1:0] q;
  logic [W-1:0] sel;

  xcvr_fall_det u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .strb_i(strb_i),
    .fall_o(fall)
  );

  always_comb begin
    if (le_i)      mode = XM_PASS;
    else if (fall) mode = XM_CAPTURE;
    else           mode = XM_HOLD;
  end

  xcvr_store #(.W(W)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode),
    .d_i   (d_i),
    .q_o   (q)
  );

  generate
    if (OE_LOW) begin : g_oe_low
      assign en = ~oe_raw_i;
    end else begin : g_oe_high
      assign en = oe_raw_i;
    end
  endgenerate

  assign sel  = (mode == XM_PASS) ? d_i : q;
  assign y_o  = en ? sel : '0;
  assign oe_o = en;

  // captured word must appear on the enabled output once holding
  assert_capture_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode == XM_CAPTURE) && mode == XM_HOLD && en) |-> (y_o == $past(d_i)));
endmodule

// File: rtl/bus_xcvr_dual.sv
module bus_xcvr_dual #(
  parameter int DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] a_o,
  output logic              a_oe_o,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] b_o,
  output logic              b_oe_o,
  input  logic              oe_ab_i,
  input  logic              le_ab_i,
  input  logic              strb_ab_i,
  input  logic              oe_ba_ni,
  input  logic              le_ba_i,
  input  logic              strb_ba_i
);
  xcvr_lane #(.W(DATA_W), .OE_LOW(1'b0)) u_ab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (a_i),
    .oe_raw_i(oe_ab_i),
    .le_i    (le_ab_i),
    .strb_i  (strb_ab_i),
    .y_o     (b_o),
    .oe_o    (b_oe_o)
  );

  xcvr_lane #(.W(DATA_W), .OE_LOW(1'b1)) u_ba (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (b_i),
    .oe_raw_i(oe_ba_ni),
    .le_i    (le_ba_i),
    .strb_i  (strb_ba_i),
    .y_o     (a_o),
    .oe_o    (a_oe_o)
  );
endmodule

// File: tb/sim_bus_xcvr_dual.sv
`timescale 1ns/1ps
module sim_bus_xcvr_dual;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic oe_ab = 1'b0, le_ab = 1'b0, strb_ab = 1'b0;
  logic oe_ba_n = 1'b1, le_ba = 1'b0, strb_ba = 1'b0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural model state
  logic [W-1:0] m_ab, m_ba;
  logic p_ab, p_ba;
  bit cap_ab, cap_ba;

  always #10 clk = ~clk;

  bus_xcvr_dual #(.DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe),
    .oe_ab_i(oe_ab), .le_ab_i(le_ab), .strb_ab_i(strb_ab),
    .oe_ba_ni(oe_ba_n), .le_ba_i(le_ba), .strb_ba_i(strb_ba)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ab <= '0; m_ba <= '0; p_ab <= 1'b0; p_ba <= 1'b0;
      cap_ab <= 1'b0; cap_ba <= 1'b0;
    end else begin
      cap_ab <= 1'b0; cap_ba <= 1'b0;
      if (le_ab) m_ab <= a_in;
      else if (p_ab && !strb_ab) begin m_ab <= a_in; cap_ab <= 1'b1; end
      if (le_ba) m_ba <= b_in;
      else if (p_ba && !strb_ba) begin m_ba <= b_in; cap_ba <= 1'b1; end
      p_ab <= strb_ab;
      p_ba <= strb_ba;
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare both directions against the model; call at negedge
  task automatic cycle_check();
    logic [W-1:0] e;
    string t;
    e = !oe_ab ? '0 : (le_ab ? a_in : m_ab);
    t = !oe_ab ? "R6" : (le_ab ? "R2" : (cap_ab ? "R4" : "R3"));
    chk(t, b_out, e);
    chk("R6", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, oe_ab});
    e = oe_ba_n ? '0 : (le_ba ? b_in : m_ba);
    t = oe_ba_n ? "R7" : (le_ba ? "R2" : (cap_ba ? "R4" : "R3"));
    chk(t, a_out, e);
    chk("R7", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, ~oe_ba_n});
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cycle_check();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    oe_ab = 1'b1; oe_ba_n = 1'b0;
    a_in = 18'h2AAAA; b_in = 18'h15555;
    #1;
    chk("R8 reset b", b_out, '0);
    chk("R8 reset a", a_out, '0);
    step();

    // R2 / R1 transparent with full-width word
    le_ab = 1'b1; a_in = 18'h3FFFF; #1;
    chk("R2 R1 pass msb", b_out, 18'h3FFFF);
    step();
    a_in = 18'h20001; #1;
    chk("R2 same cycle", b_out, 18'h20001);
    step();

    // R5 select falls: last transparent word held
    le_ab = 1'b0; a_in = 18'h0F0F0; #1;
    chk("R5 hold last pass", b_out, 18'h20001);
    step();
    // R3 input changes ignored
    a_in = 18'h12345; #1;
    chk("R3 ignore input", b_out, 18'h20001);
    step();

    // R4 rising strobe stores nothing
    strb_ab = 1'b1; a_in = 18'h11111;
    step();
    chk("R4 rise no store", b_out, 18'h20001);
    // falling strobe stores input at this edge
    strb_ab = 1'b0; a_in = 18'h2BEEF;
    step();
    chk("R4 fall store", b_out, 18'h2BEEF);
    a_in = 18'h00007; #1;
    chk("R4 stays", b_out, 18'h2BEEF);

    // R9 independence: B-to-A holds after its own pass
    le_ba = 1'b1; b_in = 18'h1C3C3;
    step();
    le_ba = 1'b0; b_in = 18'h00000;
    step();
    held = a_out;
    chk("R9 ba held", held, 18'h1C3C3);
    for (int k = 0; k < 4; k++) begin
      strb_ab = 1'b1; a_in = 18'(k * 1234);
      step();
      strb_ab = 1'b0;
      step();
      chk("R9 a_o unchanged", a_out, 18'h1C3C3);
    end

    // R6 disable gate, storage keeps updating
    oe_ab = 1'b0; le_ab = 1'b1; a_in = 18'h3A5A5; #1;
    chk("R6 disabled zero", b_out, '0);
    step();
    le_ab = 1'b0; oe_ab = 1'b1; #1;
    chk("R6 store while off", b_out, 18'h3A5A5);
    // R7 low-active enable
    oe_ba_n = 1'b1; #1;
    chk("R7 disabled zero", a_out, '0);
    chk("R7 oe low", {17'd0, a_oe}, 18'd0);
    oe_ba_n = 1'b0; #1;
    chk("R7 oe high", {17'd0, a_oe}, 18'd1);

    // random phase against model
    for (int i = 0; i < 600; i++) begin
      a_in    = W'($urandom);
      b_in    = W'($urandom);
      le_ab   = ($urandom % 4) == 0;
      le_ba   = ($urandom % 4) == 0;
      strb_ab = $urandom % 2;
      strb_ba = $urandom % 2;
      oe_ab   = ($urandom % 5) != 0;
      oe_ba_n = ($urandom % 5) == 0;
      #1;
      cycle_check();
      step();
    end

    // R8 reset mid-run clears storage
    rst_n = 1'b0; le_ab = 1'b0; le_ba = 1'b0; oe_ab = 1'b1; oe_ba_n = 1'b0;
    #1;
    chk("R8 reset b", b_out, '0);
    chk("R8 reset a", a_out, '0);
    @(negedge clk);
    rst_n = 1'b1;
    strb_ab = 1'b0;
    step();
    chk("R8 no capture after reset", b_out, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule